// File: doc/BRIEF.md
# Voice Group Trigger Controller

This block sits between the trigger pins of a voice playback chip and its player. It watches eight key inputs, one strobe input and a halt input, and turns them into one-cycle start requests carrying a 5-bit group index (groups 1..32 are indices 0..31), plus one-cycle stop requests. A static mode input selects key mode or CPU address mode. Each group has three option bits, given as parameter masks: edge or level trigger, holdable or not, and retriggerable or not.

In key mode, a key pattern is decoded into a group. The pattern must be a run of one to four adjacent keys, and a run may wrap from the last key back to the first. Each press of the strobe plays the next of the first sixteen groups in turn. In CPU mode, the low five keys form an address that is taken when the strobe is pressed. Key and strobe inputs are synchronised and then debounced by counting sample-rate ticks. The player reports the end of a group on `play_done`.

Top module: `vg_trigger_ctrl`

## Requirements
- R1: In key mode, a stable pattern with exactly one key k (bit k, k=0..7) set starts group index k.
- R2: In key mode, a stable pattern of n adjacent keys (n=2..4) whose lowest run position is s, counting cyclically so that bit 7 is followed by bit 0, starts group index (n-1)*8+s. For example, keys 7 and 0 give index 15, and keys 7, 0, 1, 2 give index 31.
- R3: Any other pattern (no key, more than four keys, or keys that are not adjacent) starts nothing.
- R4: A key or strobe change takes effect only after it has stayed unchanged for DEB_TICKS ticks. Any change before then restarts the count. While a group is playing, key changes need RETRIG_TICKS ticks instead.
- R5: In CPU mode, a debounced strobe rise starts group index keys[4:0]. keys[7:5] are ignored, and key patterns alone start nothing.
- R6: In key mode, each debounced strobe press starts group index seq_pos, where seq_pos starts at 0 and steps modulo 16.
- R7: While halt is high, a playing group is dropped with a stop pulse on the next cycle, and no start is issued.
- R8: A holdable group stops with a stop pulse when its input is released after debouncing. An unholdable group stays busy until play_done.
- R9: On play_done, a level group whose input is still held starts again with the same index. Otherwise busy clears with no stop pulse.
- R10: While busy, a new trigger restarts playback with the new group's index if the playing group is retriggerable. Otherwise the trigger is ignored and cur_grp keeps its value.
- R11: start_pulse and stop_pulse each last one cycle and never occur together. busy is high with every start_pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample-rate tick enabling the debounce counters |
| cpu_mode | input | 1 | 0 = key mode, 1 = CPU address mode |
| keys | input | 8 | Key inputs, bit 0 is the first key |
| strobe | input | 1 | Sequential-step input in key mode, address strobe in CPU mode |
| halt | input | 1 | Stop request, active high |
| play_done | input | 1 | Player finished the current group |
| start_pulse | output | 1 | One-cycle start request |
| start_grp | output | 5 | Group index for start_pulse |
| stop_pulse | output | 1 | One-cycle forced stop request |
| busy | output | 1 | A group is playing |
| cur_grp | output | 5 | Index of the group playing |
| seq_pos | output | 4 | Next group index for a sequential press |

## Verification
The assertions assume that halt and play_done are synchronous to clk and that play_done is a single-cycle pulse. They also assume that cpu_mode changes only while the block is idle. The stimulus changes every input just after a falling edge. It holds each key or strobe level for longer than the relevant debounce window, except in the directed case that tests the count restart. It pulses play_done for one cycle, and only after any release has been debounced.

// File: rtl/vgt_pkg.sv
package vgt_pkg;

   typedef enum logic {
      SRC_KEYS   = 1'b0,
      SRC_STROBE = 1'b1
   } trig_src_e;

   // bit mask of len adjacent positions from first, wrapping at width
   function automatic logic [31:0] run_mask(input int len, input int first, input int width);
      logic [31:0] m;
      m = '0;
      for (int k = 0; k < len; k++) m[(first + k) % width] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/vgt_sync.sv
module vgt_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   if (STAGES < 0) begin : g_bad
      $error("vgt_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_pass
      assign dout = din;
   end else begin : g_regs
      logic [W-1:0] stg [STAGES];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
         end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         end
      end
      assign dout = stg[STAGES-1];
   end
endmodule

// File: rtl/vgt_debounce.sv
module vgt_debounce #(
   parameter int W  = 8,
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic [W-1:0]  raw,
   input  logic [CW-1:0] limit,
   output logic [W-1:0]  stable,
   output logic          upd
);
   logic [W-1:0]  cand;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cand   <= '0;
         cnt    <= '0;
         stable <= '0;
         upd    <= 1'b0;
      end else begin
         upd <= 1'b0;
         if (raw != cand) begin
            cand <= raw;
            cnt  <= '0;
         end else if (tick && (stable != cand)) begin
            if (cnt >= limit - CW'(1)) begin
               stable <= cand;
               upd    <= 1'b1;
               cnt    <= '0;
            end else begin
               cnt <= cnt + CW'(1);
            end
         end
      end
   end

   // R4: a new stable value equals the input seen on the previous cycle
   assert_deb_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
      upd |-> (stable == $past(raw)));
endmodule

// File: rtl/vgt_decode.sv
module vgt_decode #(
   parameter int NK = 8,
   parameter int MR = 4,
   parameter int GW = 5
) (
   input  logic [NK-1:0] pat,
   output logic          valid,
   output logic [GW-1:0] grp
);
   localparam int NG = NK * MR;

   if (MR >= NK || NK > 32 || (1 << GW) < NG) begin : g_bad
      $error("vgt_decode: bad key/run/index sizing");
   end

   logic [NG-1:0] hit;

   for (genvar n = 0; n < MR; n++) begin : g_len
      for (genvar s = 0; s < NK; s++) begin : g_pos
         localparam logic [31:0] FULL = vgt_pkg::run_mask(n + 1, s, NK);
         assign hit[n*NK + s] = (pat == FULL[NK-1:0]);
      end
   end

   always_comb begin
      valid = 1'b0;
      grp   = '0;
      for (int i = 0; i < NG; i++) begin
         if (hit[i]) begin
            valid = 1'b1;
            grp   = GW'(i);
         end
      end
   end
endmodule

// File: rtl/vg_trigger_ctrl.sv
module vg_trigger_ctrl #(
   parameter int NUM_KEYS     = 8,
   parameter int MAX_RUN      = 4,
   parameter int NUM_GROUPS   = 32,
   parameter int SEQ_GROUPS   = 16,
   parameter int DEB_TICKS    = 128,
   parameter int RETRIG_TICKS = 192,
   parameter int SYNC_STAGES  = 2,
   parameter logic [NUM_GROUPS-1:0] EDGE_MASK   = '0,
   parameter logic [NUM_GROUPS-1:0] HOLD_MASK   = '0,
   parameter logic [NUM_GROUPS-1:0] RETRIG_MASK = '0
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            tick,
   input  logic                            cpu_mode,
   input  logic [NUM_KEYS-1:0]             keys,
   input  logic                            strobe,
   input  logic                            halt,
   input  logic                            play_done,
   output logic                            start_pulse,
   output logic [$clog2(NUM_GROUPS)-1:0]   start_grp,
   output logic                            stop_pulse,
   output logic                            busy,
   output logic [$clog2(NUM_GROUPS)-1:0]   cur_grp,
   output logic [$clog2(SEQ_GROUPS)-1:0]   seq_pos
);
   import vgt_pkg::*;

   localparam int GW = $clog2(NUM_GROUPS);
   localparam int SW = $clog2(SEQ_GROUPS);
   localparam int CW = $clog2(RETRIG_TICKS + 1);

   if (NUM_GROUPS != NUM_KEYS * MAX_RUN || GW > NUM_KEYS) begin : g_chk_grp
      $error("vg_trigger_ctrl: group count does not match key sizing");
   end
   if (DEB_TICKS < 1 || RETRIG_TICKS < DEB_TICKS) begin : g_chk_deb
      $error("vg_trigger_ctrl: debounce limits out of order");
   end
   if (SEQ_GROUPS > NUM_GROUPS || SEQ_GROUPS < 2) begin : g_chk_seq
      $error("vg_trigger_ctrl: bad sequential range");
   end

   // input synchronisation
   logic [NUM_KEYS:0] in_s;
   vgt_sync #(.W(NUM_KEYS + 1), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din({strobe, keys}), .dout(in_s));

   logic [NUM_KEYS-1:0] keys_s;
   logic                strobe_s;
   assign keys_s   = in_s[NUM_KEYS-1:0];
   assign strobe_s = in_s[NUM_KEYS];

   // debouncing
   logic                busy_q;
   logic [NUM_KEYS-1:0] key_stable;
   logic                key_upd;
   logic [CW-1:0]       key_limit;
   logic                stb_stable;
   logic                stb_upd;

   assign key_limit = busy_q ? CW'(RETRIG_TICKS) : CW'(DEB_TICKS);

   vgt_debounce #(.W(NUM_KEYS), .CW(CW)) u_deb_keys (
      .clk(clk), .rst_n(rst_n), .tick(tick), .raw(keys_s),
      .limit(key_limit), .stable(key_stable), .upd(key_upd));

   vgt_debounce #(.W(1), .CW(CW)) u_deb_stb (
      .clk(clk), .rst_n(rst_n), .tick(tick), .raw(strobe_s),
      .limit(CW'(DEB_TICKS)), .stable(stb_stable), .upd(stb_upd));

   // pattern decode
   logic          key_valid;
   logic [GW-1:0] key_grp;
   vgt_decode #(.NK(NUM_KEYS), .MR(MAX_RUN), .GW(GW)) u_dec (
      .pat(key_stable), .valid(key_valid), .grp(key_grp));

   // control state
   logic [GW-1:0] cur_q, sgrp_q;
   logic [SW-1:0] seq_q;
   trig_src_e     src_q;
   logic          start_q, stop_q;

   logic          stb_rise, trig_evt, held;
   logic [GW-1:0] trig_grp;
   trig_src_e     trig_src;

   assign stb_rise = stb_upd && stb_stable;

   always_comb begin
      trig_evt = 1'b0;
      trig_grp = '0;
      trig_src = SRC_KEYS;
      if (!cpu_mode && key_upd && key_valid) begin
         trig_evt = 1'b1;
         trig_grp = key_grp;
      end else if (stb_rise) begin
         trig_evt = 1'b1;
         trig_src = SRC_STROBE;
         trig_grp = cpu_mode ? keys_s[GW-1:0] : GW'(seq_q);
      end
   end

   assign held = (src_q == SRC_STROBE) ? stb_stable
                                       : (key_valid && (key_grp == cur_q));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         cur_q   <= '0;
         sgrp_q  <= '0;
         src_q   <= SRC_KEYS;
         seq_q   <= '0;
         start_q <= 1'b0;
         stop_q  <= 1'b0;
      end else begin
         start_q <= 1'b0;
         stop_q  <= 1'b0;
         if (!cpu_mode && stb_rise) seq_q <= seq_q + SW'(1);
         if (halt) begin
            if (busy_q) begin
               stop_q <= 1'b1;
               busy_q <= 1'b0;
            end
         end else if (trig_evt && (!busy_q || RETRIG_MASK[cur_q])) begin
            start_q <= 1'b1;
            sgrp_q  <= trig_grp;
            cur_q   <= trig_grp;
            src_q   <= trig_src;
            busy_q  <= 1'b1;
         end else if (busy_q && HOLD_MASK[cur_q] && !held) begin
            stop_q <= 1'b1;
            busy_q <= 1'b0;
         end else if (busy_q && play_done) begin
            if (!EDGE_MASK[cur_q] && held) begin
               start_q <= 1'b1;
               sgrp_q  <= cur_q;
            end else begin
               busy_q <= 1'b0;
            end
         end
      end
   end

   assign start_pulse = start_q;
   assign start_grp   = sgrp_q;
   assign stop_pulse  = stop_q;
   assign busy        = busy_q;
   assign cur_grp     = cur_q;
   assign seq_pos     = seq_q;

   assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_pulse && stop_pulse));
   assert_start_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> busy);
   assert_halt_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> (!busy && !start_pulse));
   assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stop_pulse |-> (!busy && $past(busy)));
   assert_nonretrig_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (start_pulse && $past(busy) && !$past(play_done)) |-> RETRIG_MASK[$past(cur_grp)]);
endmodule

// File: tb/sim_vg_trigger_ctrl.sv
module sim_vg_trigger_ctrl;
   localparam logic [31:0] EDGE_M   = 32'hFF00_FF00;
   localparam logic [31:0] HOLD_M   = 32'hFFFF_0000;
   localparam logic [31:0] RETRIG_M = 32'h0F0F_0F0F;

   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, cpu_mode = 1'b0;
   logic [7:0] keys = '0;
   logic strobe = 1'b0, halt = 1'b0, play_done = 1'b0;
   logic start_pulse, stop_pulse, busy;
   logic [4:0] start_grp, cur_grp;
   logic [3:0] seq_pos;

   int n_tests = 0, n_fail = 0, n_start = 0, n_stop = 0;
   int last_grp = 0;
   bit finished = 0;

   vg_trigger_ctrl #(.EDGE_MASK(EDGE_M), .HOLD_MASK(HOLD_M), .RETRIG_MASK(RETRIG_M)) u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cpu_mode(cpu_mode), .keys(keys),
      .strobe(strobe), .halt(halt), .play_done(play_done),
      .start_pulse(start_pulse), .start_grp(start_grp), .stop_pulse(stop_pulse),
      .busy(busy), .cur_grp(cur_grp), .seq_pos(seq_pos));

   always #5 clk = ~clk;

   initial forever begin
      @(negedge clk);
      tick = ~tick;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (start_pulse) begin
            n_start++;
            last_grp = int'(start_grp);
         end
         if (stop_pulse) n_stop++;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic done_pulse();
      play_done = 1'b1;
      cyc(1);
      play_done = 1'b0;
      cyc(2);
   endtask

   // expected group from the requirement wording: find the run start, rebuild the run
   function automatic int exp_group(input logic [7:0] p);
      int n, st;
      logic [7:0] m;
      n = $countones(p);
      st = -1;
      if (n < 1 || n > 4) return -1;
      for (int i = 0; i < 8; i++)
         if (p[i] && !p[(i + 7) % 8]) st = i;
      if (st < 0) return -1;
      m = '0;
      for (int k = 0; k < n; k++) m[(st + k) % 8] = 1'b1;
      if (m != p) return -1;
      return (n - 1) * 8 + st;
   endfunction

   // one full key-mode trial from idle
   task automatic key_trial(input logic [7:0] p);
      int g, s0, st0;
      g = exp_group(p);
      s0 = n_start;
      keys = p;
      cyc(240);
      chk(n_start == s0, "R4 start before debounce", n_start - s0, 0);
      cyc(80);
      if (g < 0) begin
         chk(n_start == s0 && !busy, "R3 invalid pattern", n_start - s0, 0);
         keys = '0;
         cyc(300);
      end else begin
         chk(n_start == s0 + 1 && last_grp == g, "R1 R2 decoded group", last_grp, g);
         st0 = n_stop;
         keys = '0;
         cyc(450);
         if (HOLD_M[g])
            chk(!busy && n_stop == st0 + 1, "R8 holdable release", n_stop - st0, 1);
         else
            chk(busy && n_stop == st0, "R8 unholdable keeps busy", int'(busy), 1);
         done_pulse();
         chk(!busy && n_start == s0 + 1, "R9 done after release", int'(busy), 0);
      end
   endtask

   initial begin
      int s0, st0, dummy;
      logic [7:0] p;
      logic [4:0] a;
      dummy = $urandom(32'd20240517);
      cyc(4);
      chk(!busy && !start_pulse && !stop_pulse && seq_pos == 0, "R11 reset state", int'(busy), 0);
      rst_n = 1'b1;
      cyc(4);

      // R1/R2: every valid window, directed
      for (int n = 1; n <= 4; n++)
         for (int s = 0; s < 8; s++) begin
            p = '0;
            for (int k = 0; k < n; k++) p[(s + k) % 8] = 1'b1;
            key_trial(p);
         end

      // R3: directed bad patterns, then random bytes
      key_trial(8'h05);
      key_trial(8'hFF);
      key_trial(8'h1F);
      for (int i = 0; i < 20; i++) key_trial(8'($urandom));

      // R4: change inside the window restarts the count
      s0 = n_start;
      keys = 8'h01;
      cyc(200);
      keys = 8'h02;
      cyc(240);
      chk(n_start == s0, "R4 restart on change", n_start - s0, 0);
      cyc(80);
      chk(n_start == s0 + 1 && last_grp == 1, "R4 new pattern wins", last_grp, 1);
      keys = '0; cyc(450); done_pulse();

      // R9: level group replays while held
      s0 = n_start;
      keys = 8'h01; cyc(320);
      done_pulse();
      chk(n_start == s0 + 2 && last_grp == 0 && busy, "R9 level replay", n_start - s0, 2);
      keys = '0; cyc(450); done_pulse();
      chk(!busy, "R9 level stops after release", int'(busy), 0);

      // R9: edge group ends on done even while held
      s0 = n_start;
      keys = 8'h03; cyc(320);
      done_pulse();
      chk(n_start == s0 + 1 && !busy, "R9 edge ends", int'(busy), 0);
      keys = '0; cyc(450);

      // R10: retriggerable group 0 restarts with group 1 after the longer window
      s0 = n_start;
      keys = 8'h01; cyc(320);
      keys = '0; cyc(450);
      keys = 8'h02; cyc(360);
      chk(n_start == s0 + 1, "R4 retrigger window", n_start - s0, 1);
      cyc(60);
      chk(n_start == s0 + 2 && last_grp == 1 && busy, "R10 retrigger restart", last_grp, 1);
      keys = '0; cyc(450); done_pulse();

      // R10: non-retriggerable group 4 ignores group 5
      s0 = n_start;
      keys = 8'h10; cyc(320);
      keys = '0; cyc(450);
      keys = 8'h20; cyc(500);
      chk(n_start == s0 + 1 && busy && cur_grp == 4, "R10 ignored trigger", int'(cur_grp), 4);
      keys = '0; cyc(450); done_pulse();

      // R7: halt drops playback and blocks starts
      s0 = n_start; st0 = n_stop;
      keys = 8'h01; cyc(320);
      halt = 1'b1; cyc(2);
      chk(!busy && n_stop == st0 + 1, "R7 halt stops", n_stop - st0, 1);
      keys = '0; cyc(450);
      keys = 8'h02; cyc(320);
      chk(n_start == s0 + 1 && !busy, "R7 no start while halted", n_start - s0, 1);
      halt = 1'b0; keys = '0; cyc(450);

      // R6: sequential strobe presses
      for (int i = 0; i < 17; i++) begin
         s0 = n_start;
         strobe = 1'b1; cyc(320);
         chk(n_start == s0 + 1 && last_grp == (i % 16), "R6 sequential group", last_grp, i % 16);
         strobe = 1'b0; cyc(300);
         done_pulse();
      end
      chk(seq_pos == 1, "R6 sequence wraps", int'(seq_pos), 1);

      // R5: CPU address mode
      cpu_mode = 1'b1;
      cyc(4);
      s0 = n_start;
      keys = 8'h01; cyc(400);
      chk(n_start == s0, "R5 keys alone ignored", n_start - s0, 0);
      keys = '0; cyc(300);
      for (int i = 0; i < 10; i++) begin
         a = (i == 0) ? 5'd31 : 5'($urandom);
         s0 = n_start; st0 = n_stop;
         keys = {3'($urandom), a};
         cyc(6);
         strobe = 1'b1; cyc(320);
         chk(n_start == s0 + 1 && last_grp == int'(a), "R5 address start", last_grp, int'(a));
         strobe = 1'b0; keys = '0; cyc(300);
         if (HOLD_M[a]) chk(!busy && n_stop == st0 + 1, "R8 strobe release", n_stop - st0, 1);
         else           chk(busy, "R8 strobe unholdable", int'(busy), 1);
         done_pulse();
      end
      chk(seq_pos == 1, "R5 strobe does not step sequence", int'(seq_pos), 1);

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule